// File: doc/BRIEF.md
# MIDI Receive Timestamping Queue Writer

This block sits between a MIDI serial receiver and a receive queue. It accepts one received byte at a time through a valid/ready pair. It also watches a free-running time counter. Every byte with its most significant bit set is a status or command byte. Such a byte goes into the queue with a snapshot of the time taken in the cycle it was accepted, and that snapshot is written as tagged entries directly after the byte. A byte with a clear top bit is a data byte. It goes into the queue on its own and counts as received at the time of the status byte that led it, so it carries no stamp.

Real-time bytes can turn up between the data bytes of a longer message. They are handled like any other status byte and get their own stamp. A filter enable discards the keep-alive byte FEh completely, so a sender that repeats it all the time does not fill the queue. Before a byte is accepted, the block checks the queue's reported free space against everything the byte needs, counting a write that is still in flight. If the whole record does not fit, the byte is dropped and a sticky overrun flag is raised, so a byte never appears in the queue without its stamp.

Top module: `midi_stamp_writer`

## Requirements
- R1: After reset, `wr_en` and `overrun` are 0 and `rx_ready` is 1.
- R2: A byte accepted with bit 7 set appears on the queue write port in the next cycle with `wr_tag`=0. The two cycles after that each carry an entry with `wr_tag`=1: first bits 7:0, then bits 15:8, of the `time_now` value present on the clock edge that accepted the byte.
- R3: A byte accepted with bit 7 clear is written once, with `wr_tag`=0, in the next cycle, and no tagged entry follows it.
- R4: `rx_ready` is 0 in the two cycles after a status byte is accepted, while its stamp entries are still to be written, and it returns to 1 after that.
- R5: When `drop_sense_en`=1, an accepted byte of value FEh produces no write and does not set `overrun`. When `drop_sense_en`=0, FEh is stamped like any other status byte.
- R6: A real-time byte (F8h to FFh) accepted between the data bytes of a message is written with its own stamp. The data bytes that follow it are written unchanged and unstamped.
- R7: A byte fits when `fifo_free` is at least its entry count (3 for a status byte, 1 for a data byte) plus 1 if `wr_en` is high in the accepting cycle. A byte that does not fit writes nothing and sets `overrun`. A write never happens while `fifo_free` is 0.
- R8: `overrun` stays at 1 once set, through later traffic, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receiver offers a byte |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Block can take a byte this cycle |
| time_now | input | TS_W | Free-running time counter |
| drop_sense_en | input | 1 | Discard FEh bytes when 1 |
| fifo_free | input | FREE_W | Free entries in the receive queue |
| wr_en | output | 1 | Queue write strobe |
| wr_data | output | 8 | Entry data byte |
| wr_tag | output | 1 | 1 marks a timestamp entry |
| overrun | output | 1 | Sticky: a record was dropped for lack of room |

## Verification
The bench builds the block with a 16-bit timestamp and a 4-bit free count, and it models an eight-entry queue. The queue can then be filled with a few bytes, which brings within reach the exact-fit case (free space of three for a status byte), the case one entry short, and a data byte arriving into a full queue. The time counter starts just below a low-byte wrap, so the two stamp bytes differ and their order is visible.

// File: rtl/midi_stamp_pkg.sv
package midi_stamp_pkg;

    localparam logic [7:0] SENSE_CODE = 8'hFE;

    typedef enum logic [1:0] {
        KIND_DATA   = 2'd0,
        KIND_STATUS = 2'd1,
        KIND_DROP   = 2'd2
    } byte_kind_e;

    typedef struct packed {
        logic       is_stamp;
        logic [7:0] data;
    } q_entry_t;

    function automatic logic has_status_bit(input logic [7:0] b);
        return b[7];
    endfunction

    function automatic int stamp_entries(input int ts_bits);
        return (ts_bits + 7) / 8;
    endfunction

endpackage

// File: rtl/midi_byte_classifier.sv
module midi_byte_classifier
    import midi_stamp_pkg::*;
(
    input  logic [7:0] byte_in,
    input  logic       drop_en,
    output byte_kind_e kind
);
    always_comb begin
        if (drop_en && byte_in == SENSE_CODE)
            kind = KIND_DROP;
        else if (has_status_bit(byte_in))
            kind = KIND_STATUS;
        else
            kind = KIND_DATA;
    end
endmodule

// File: rtl/midi_room_check.sv
module midi_room_check
    import midi_stamp_pkg::*;
#(
    parameter int FREE_W  = 4,
    parameter int STAMP_N = 2
) (
    input  byte_kind_e        kind,
    input  logic [FREE_W-1:0] free_cnt,
    input  logic              in_flight,
    output logic              fits
);
    localparam int NEED_W = FREE_W + 2;

    logic [NEED_W-1:0] need;
    logic [NEED_W-1:0] have;

    always_comb begin
        need = NEED_W'(1) + NEED_W'(in_flight);
        if (kind == KIND_STATUS)
            need = need + NEED_W'(STAMP_N);
        have = NEED_W'(free_cnt);
        fits = (have >= need);
    end
endmodule

// File: rtl/midi_stamp_sequencer.sv
module midi_stamp_sequencer
    import midi_stamp_pkg::*;
#(
    parameter int TS_W    = 16,
    parameter int STAMP_N = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            push_stamp,
    input  logic [7:0]      push_byte,
    input  logic [TS_W-1:0] snap_time,
    output logic            busy,
    output logic            out_valid,
    output q_entry_t        out_entry
);
    localparam int SH_W  = STAMP_N * 8;
    localparam int PND_W = $clog2(STAMP_N + 1);

    logic [SH_W-1:0]  shreg;
    logic [PND_W-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            pend      <= '0;
            out_valid <= 1'b0;
            out_entry <= '0;
        end else if (pend != '0) begin
            out_valid          <= 1'b1;
            out_entry.is_stamp <= 1'b1;
            out_entry.data     <= shreg[7:0];
            shreg              <= shreg >> 8;
            pend               <= pend - PND_W'(1);
        end else if (push) begin
            out_valid          <= 1'b1;
            out_entry.is_stamp <= 1'b0;
            out_entry.data     <= push_byte;
            if (push_stamp) begin
                shreg <= SH_W'(snap_time);
                pend  <= PND_W'(STAMP_N);
            end
        end else begin
            out_valid <= 1'b0;
        end
    end

    assign busy = (pend != '0);
endmodule

// File: rtl/midi_stamp_writer.sv
module midi_stamp_writer
    import midi_stamp_pkg::*;
#(
    parameter int TS_W   = 16,
    parameter int FREE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              rx_ready,
    input  logic [TS_W-1:0]   time_now,
    input  logic              drop_sense_en,
    input  logic [FREE_W-1:0] fifo_free,
    output logic              wr_en,
    output logic [7:0]        wr_data,
    output logic              wr_tag,
    output logic              overrun
);
    localparam int STAMP_N = stamp_entries(TS_W);

    byte_kind_e kind;
    logic       fits;
    logic       accept;
    logic       push;
    logic       busy;
    q_entry_t   entry;

    midi_byte_classifier u_class (
        .byte_in (rx_byte),
        .drop_en (drop_sense_en),
        .kind    (kind)
    );

    midi_room_check #(.FREE_W(FREE_W), .STAMP_N(STAMP_N)) u_room (
        .kind      (kind),
        .free_cnt  (fifo_free),
        .in_flight (wr_en),
        .fits      (fits)
    );

    assign rx_ready = !busy;
    assign accept   = rx_valid && rx_ready;
    assign push     = accept && (kind != KIND_DROP) && fits;

    midi_stamp_sequencer #(.TS_W(TS_W), .STAMP_N(STAMP_N)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_stamp (kind == KIND_STATUS),
        .push_byte  (rx_byte),
        .snap_time  (time_now),
        .busy       (busy),
        .out_valid  (wr_en),
        .out_entry  (entry)
    );

    assign wr_data = entry.data;
    assign wr_tag  = entry.is_stamp;

    always_ff @(posedge clk) begin
        if (rst)
            overrun <= 1'b0;
        else if (accept && kind != KIND_DROP && !fits)
            overrun <= 1'b1;
    end
endmodule

// File: rtl/midi_stamp_writer_chk.sv
module midi_stamp_writer_chk #(
    parameter int TS_W   = 16,
    parameter int FREE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic [7:0]        rx_byte,
    input logic              rx_ready,
    input logic [TS_W-1:0]   time_now,
    input logic              drop_sense_en,
    input logic [FREE_W-1:0] fifo_free,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic              wr_tag,
    input logic              overrun
);
    logic status_out;
    assign status_out = wr_en && !wr_tag && wr_data[7];

    assert_stamp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        status_out |=> (wr_en && wr_tag && wr_data == 8'($past(time_now, 2))));

    assert_data_unstamped_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_tag && !wr_data[7]) |=> !(wr_en && wr_tag));

    assert_hold_off_R4: assert property (@(posedge clk) disable iff (rst)
        status_out |-> !rx_ready);

    assert_sense_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ready && drop_sense_en && rx_byte == 8'hFE) |=> !wr_en);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> fifo_free != '0);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
endmodule

bind midi_stamp_writer midi_stamp_writer_chk #(.TS_W(TS_W), .FREE_W(FREE_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .rx_valid      (rx_valid),
    .rx_byte       (rx_byte),
    .rx_ready      (rx_ready),
    .time_now      (time_now),
    .drop_sense_en (drop_sense_en),
    .fifo_free     (fifo_free),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .wr_tag        (wr_tag),
    .overrun       (overrun)
);

// File: tb/midi_stamp_writer_tb_top.sv
module midi_stamp_writer_tb_top;
    localparam int TS_W   = 16;
    localparam int FREE_W = 4;
    localparam int DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_byte = 8'h00;
    logic              rx_ready;
    logic [TS_W-1:0]   time_now;
    logic              drop_sense_en = 1'b0;
    logic [FREE_W-1:0] fifo_free;
    logic              wr_en;
    logic [7:0]        wr_data;
    logic              wr_tag;
    logic              overrun;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int qcount = 0;
    logic drain_req = 1'b0;

    logic [7:0] log_data [0:255];
    logic       log_tag  [0:255];
    int         log_n = 0;

    always #2.5 clk = ~clk;

    midi_stamp_writer #(.TS_W(TS_W), .FREE_W(FREE_W)) dut_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_ready(rx_ready), .time_now(time_now), .drop_sense_en(drop_sense_en),
        .fifo_free(fifo_free), .wr_en(wr_en), .wr_data(wr_data),
        .wr_tag(wr_tag), .overrun(overrun)
    );

    assign fifo_free = FREE_W'(DEPTH - qcount);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) time_now <= 16'h12FC;
        else     time_now <= time_now + 16'd1;
        if (drain_req) qcount <= 0;
        else if (wr_en) qcount <= qcount + 1;
        if (wr_en && log_n < 256) begin
            log_data[log_n] <= wr_data;
            log_tag[log_n]  <= wr_tag;
            log_n           <= log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_entry(input int idx, input bit tag, input logic [7:0] d,
                               input string req);
        check(idx < log_n && log_tag[idx] == tag && log_data[idx] == d, req,
              $sformatf("entry %0d", idx),
              (idx < log_n) ? {23'd0, log_tag[idx], log_data[idx]} : -1,
              {23'd0, tag, d});
    endtask

    task automatic send(input logic [7:0] b, output logic [15:0] t);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        while (!rx_ready) @(negedge clk);
        t = time_now;
        @(posedge clk);
        #1 rx_valid = 1'b0;
    endtask

    task automatic idle();
        repeat (5) @(negedge clk);
    endtask

    task automatic drain();
        @(negedge clk); drain_req = 1'b1;
        @(negedge clk); drain_req = 1'b0;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(wr_en == 1'b0, "R1", "wr_en after reset", wr_en, 0);
        check(overrun == 1'b0, "R1", "overrun after reset", overrun, 0);
        check(rx_ready == 1'b1, "R1", "rx_ready after reset", rx_ready, 1);
    endtask

    task automatic test_status_stamp();
        logic [15:0] t, tx;
        int n0;
        drain(); n0 = log_n;
        send(8'h90, t); send(8'h3C, tx); send(8'h40, tx);
        idle();
        check_entry(n0,     1'b0, 8'h90,   "R2");
        check_entry(n0 + 1, 1'b1, t[7:0],  "R2");
        check_entry(n0 + 2, 1'b1, t[15:8], "R2");
        check_entry(n0 + 3, 1'b0, 8'h3C,   "R3");
        check_entry(n0 + 4, 1'b0, 8'h40,   "R3");
        check(log_n == n0 + 5, "R3", "entry count", log_n - n0, 5);
    endtask

    task automatic test_backpressure();
        drain();
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'hC5;
        @(posedge clk); #1 rx_valid = 1'b0;
        @(negedge clk);
        check(rx_ready == 1'b0, "R4", "ready one cycle after status", rx_ready, 0);
        @(negedge clk);
        check(rx_ready == 1'b0, "R4", "ready two cycles after status", rx_ready, 0);
        @(negedge clk);
        check(rx_ready == 1'b1, "R4", "ready after stamps", rx_ready, 1);
        idle();
    endtask

    task automatic test_realtime_mid();
        logic [15:0] t0, t1, tx;
        int n0;
        drain(); n0 = log_n;
        send(8'h91, t0); send(8'h3C, tx); send(8'hF8, t1); send(8'h50, tx);
        idle();
        check_entry(n0 + 3, 1'b0, 8'h3C,    "R6");
        check_entry(n0 + 4, 1'b0, 8'hF8,    "R6");
        check_entry(n0 + 5, 1'b1, t1[7:0],  "R6");
        check_entry(n0 + 6, 1'b1, t1[15:8], "R6");
        check_entry(n0 + 7, 1'b0, 8'h50,    "R6");
        check(log_n == n0 + 8, "R6", "entry count", log_n - n0, 8);
    endtask

    task automatic test_sense();
        logic [15:0] t;
        int n0;
        drain(); n0 = log_n;
        drop_sense_en = 1'b1;
        send(8'hFE, t);
        idle();
        check(log_n == n0, "R5", "writes for filtered FE", log_n - n0, 0);
        check(overrun == 1'b0, "R5", "overrun after filtered FE", overrun, 0);
        drop_sense_en = 1'b0;
        send(8'hFE, t);
        idle();
        check_entry(n0,     1'b0, 8'hFE,   "R5");
        check_entry(n0 + 1, 1'b1, t[7:0],  "R5");
        check_entry(n0 + 2, 1'b1, t[15:8], "R5");
    endtask

    task automatic test_overrun();
        logic [15:0] t;
        int n0;
        drain();
        for (int i = 0; i < 5; i++) begin send(8'h10, t); idle(); end
        n0 = log_n;
        send(8'hB0, t);
        idle();
        check(log_n == n0 + 3, "R7", "exact fit with free 3", log_n - n0, 3);
        check_entry(n0 + 2, 1'b1, t[15:8], "R7");
        check(overrun == 1'b0, "R7", "overrun at exact fit", overrun, 0);
        n0 = log_n;
        send(8'h22, t);
        idle();
        check(log_n == n0, "R7", "data into full queue", log_n - n0, 0);
        check(overrun == 1'b1, "R7", "overrun on full queue", overrun, 1);
        drain();
        for (int i = 0; i < 6; i++) begin send(8'h11, t); idle(); end
        n0 = log_n;
        send(8'hB1, t);
        idle();
        check(log_n == n0, "R7", "status with free 2", log_n - n0, 0);
        send(8'h33, t);
        idle();
        check_entry(n0, 1'b0, 8'h33, "R7");
        drain();
        send(8'h92, t); idle();
        check(overrun == 1'b1, "R8", "overrun sticky", overrun, 1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(overrun == 1'b0, "R8", "overrun cleared by reset", overrun, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_status_stamp();
        test_backpressure();
        test_realtime_mid();
        test_sense();
        test_overrun();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule